// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry

This block is the register-and-arithmetic core of a small 4-bit controller. It holds an accumulator, a temporary register, an 8-bit extension register and a single carry flag. Each clock it executes at most one micro-operation, given as an encoded opcode. An operation may take a memory nibble and an immediate nibble as operands, and its result is written back into the registers.

The arithmetic operations are add-with-carry, add-memory and add-immediate. The logic operations are AND and OR with the memory nibble. The carry operations are rotate-right through carry, set carry and clear carry. The remaining operations move data between the accumulator, the temporary register and the extension register. Only add-with-carry and the rotate change the carry through arithmetic; the other additions leave it untouched. All register contents appear directly on output ports. The extension register is not reset, so software must write it before it reads it.

Top module: `nib_acc_core`

## Requirements
- R1: A synchronous reset sets the accumulator, the temporary register and the carry to 0 at the next clock edge. The extension register is not reset.
- R2: Opcode 1 (add with carry) writes the low 4 bits of acc + mem + carry into the accumulator and writes the carry out of bit 3 into the carry flag.
- R3: Opcode 2 (add memory) writes (acc + mem) mod 16 into the accumulator. Opcode 3 (add immediate) writes (acc + imm) mod 16 into the accumulator. Neither changes the carry.
- R4: Opcode 4 writes acc AND mem into the accumulator. Opcode 5 writes acc OR mem into the accumulator. Neither changes the carry.
- R5: Opcode 6 (rotate right through carry) moves acc bit 0 into the carry, shifts the accumulator right by one bit and puts the previous carry into acc bit 3.
- R6: Opcode 7 sets the carry to 1 and opcode 8 clears it to 0. Neither changes the accumulator.
- R7: Opcode 9 loads the extension register with the temporary register in bits 7:4 and the accumulator in bits 3:0. No other opcode changes the extension register.
- R8: Opcode 10 splits the extension register: bits 7:4 go to the temporary register and bits 3:0 go to the accumulator.
- R9: Opcode 11 copies the temporary register into the accumulator. Opcode 12 copies the accumulator into the temporary register.
- R10: Opcode 0 and the unused codes 13 to 15 leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Encoded micro-operation |
| mem_i | input | DATA_W | Memory operand nibble |
| imm_i | input | DATA_W | Immediate operand nibble |
| acc_o | output | DATA_W | Accumulator |
| tmp_o | output | DATA_W | Temporary register |
| ext_o | output | 2*DATA_W | Extension register |
| cy_o | output | 1 | Carry flag |

## Verification
The bench builds the block with the default DATA_W of 4. At this width, add-with-carry can be checked exhaustively: every accumulator value, every memory value and both carry-in values, 512 cases in total. This covers every carry-out boundary, including 15 + 15 + 1 and the cases where the carry-in alone causes the overflow. The rotate is checked with both carry values, and the extension register is checked with distinct upper and lower nibbles so that a swapped half would show.

// File: rtl/nib_pkg.sv
package nib_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADDC = 4'd1,
        OP_ADDM = 4'd2,
        OP_ADDI = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_RAR  = 4'd6,
        OP_SETC = 4'd7,
        OP_CLRC = 4'd8,
        OP_LDE  = 4'd9,
        OP_SPLE = 4'd10,
        OP_B2A  = 4'd11,
        OP_A2B  = 4'd12
    } op_e;

    typedef struct packed {
        logic addc;
        logic addm;
        logic addi;
        logic land;
        logic lor;
        logic rar;
        logic setc;
        logic clrc;
        logic lde;
        logic sple;
        logic b2a;
        logic a2b;
    } dec_t;

endpackage

// File: rtl/nib_opdec.sv
module nib_opdec
    import nib_pkg::*;
(
    input  logic [3:0] op_i,
    output dec_t       dec_o
);
    always_comb begin
        dec_o = '0;
        case (op_i)
            OP_ADDC: dec_o.addc = 1'b1;
            OP_ADDM: dec_o.addm = 1'b1;
            OP_ADDI: dec_o.addi = 1'b1;
            OP_AND:  dec_o.land = 1'b1;
            OP_OR:   dec_o.lor  = 1'b1;
            OP_RAR:  dec_o.rar  = 1'b1;
            OP_SETC: dec_o.setc = 1'b1;
            OP_CLRC: dec_o.clrc = 1'b1;
            OP_LDE:  dec_o.lde  = 1'b1;
            OP_SPLE: dec_o.sple = 1'b1;
            OP_B2A:  dec_o.b2a  = 1'b1;
            OP_A2B:  dec_o.a2b  = 1'b1;
            default: dec_o = '0;
        endcase
    end
endmodule

// File: rtl/nib_adder.sv
module nib_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] c;
    assign c[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
        assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = c[W];
endmodule

// File: rtl/nib_acc_core.sv
module nib_acc_core
    import nib_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          op_i,
    input  logic [DATA_W-1:0]   mem_i,
    input  logic [DATA_W-1:0]   imm_i,
    output logic [DATA_W-1:0]   acc_o,
    output logic [DATA_W-1:0]   tmp_o,
    output logic [2*DATA_W-1:0] ext_o,
    output logic                cy_o
);
    localparam int EXT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] tmp;
        logic              cy;
    } core_t;

    core_t            st_d, st_q;
    logic [EXT_W-1:0] ext_d, ext_q;
    dec_t             dec;

    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;

    nib_opdec u_dec (
        .op_i  (op_i),
        .dec_o (dec)
    );

    // one shared adder: operand and carry-in are chosen by the opcode
    assign add_b   = dec.addi ? imm_i : mem_i;
    assign add_cin = dec.addc & st_q.cy;

    nib_adder #(.W(DATA_W)) u_add (
        .a_i    (st_q.acc),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    always_comb begin
        st_d  = st_q;
        ext_d = ext_q;
        if (dec.addc) begin
            st_d.acc = add_sum;
            st_d.cy  = add_cout;
        end else if (dec.addm || dec.addi) begin
            st_d.acc = add_sum;
        end else if (dec.land) begin
            st_d.acc = st_q.acc & mem_i;
        end else if (dec.lor) begin
            st_d.acc = st_q.acc | mem_i;
        end else if (dec.rar) begin
            st_d.acc = {st_q.cy, st_q.acc[DATA_W-1:1]};
            st_d.cy  = st_q.acc[0];
        end else if (dec.setc) begin
            st_d.cy = 1'b1;
        end else if (dec.clrc) begin
            st_d.cy = 1'b0;
        end else if (dec.lde) begin
            ext_d = {st_q.tmp, st_q.acc};
        end else if (dec.sple) begin
            st_d.tmp = ext_q[EXT_W-1:DATA_W];
            st_d.acc = ext_q[DATA_W-1:0];
        end else if (dec.b2a) begin
            st_d.acc = st_q.tmp;
        end else if (dec.a2b) begin
            st_d.tmp = st_q.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // extension register deliberately has no reset
    always_ff @(posedge clk) begin
        ext_q <= ext_d;
    end

    assign acc_o = st_q.acc;
    assign tmp_o = st_q.tmp;
    assign cy_o  = st_q.cy;
    assign ext_o = ext_q;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && tmp_o == '0 && cy_o == 1'b0));

    p_addc_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADDC) |=>
        ({cy_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(mem_i)}
                           + {{DATA_W{1'b0}}, $past(cy_o)})));

    p_cy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADDM || op_i == OP_ADDI) |=> $stable(cy_o));

    p_cy_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_AND || op_i == OP_OR) |=> $stable(cy_o));

    p_rar_r5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_RAR) |=>
        (cy_o == $past(acc_o[0]) && acc_o[DATA_W-1] == $past(cy_o)));

    p_setc_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SETC) |=> (cy_o && $stable(acc_o)));

    p_clrc_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLRC) |=> (!cy_o && $stable(acc_o)));

    p_lde_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_LDE) |=> (ext_o == {$past(tmp_o), $past(acc_o)}));

    p_ext_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_LDE) |=> $stable(ext_o));

    p_sple_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SPLE) |=> ({tmp_o, acc_o} == $past(ext_o)));

    p_b2a_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_B2A) |=> (acc_o == $past(tmp_o)));

    p_a2b_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_A2B) |=> (tmp_o == $past(acc_o)));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NOP || op_i > OP_A2B) |=>
        ($stable(acc_o) && $stable(tmp_o) && $stable(cy_o)));

endmodule

// File: tb/tb_nib_acc_core.sv
module tb_nib_acc_core;
    import nib_pkg::*;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   op_i;
    logic [W-1:0] mem_i, imm_i;
    logic [W-1:0] acc_o, tmp_o;
    logic [2*W-1:0] ext_o;
    logic         cy_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    nib_acc_core #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .op_i(op_i), .mem_i(mem_i), .imm_i(imm_i),
        .acc_o(acc_o), .tmp_o(tmp_o), .ext_o(ext_o), .cy_o(cy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // apply one op for exactly one clock edge; returns at a falling edge
    task automatic run_op(input logic [3:0] op, input logic [W-1:0] m, input logic [W-1:0] im);
        op_i = op; mem_i = m; imm_i = im;
        @(negedge clk);
        op_i = OP_NOP;
    endtask

    task automatic set_acc(input logic [W-1:0] v);
        run_op(OP_AND, '0, '0);
        run_op(OP_ADDI, '0, v);
    endtask

    task automatic set_cy(input logic v);
        run_op(v ? OP_SETC : OP_CLRC, '0, '0);
    endtask

    task automatic t_reset;
        rst = 1'b1; op_i = OP_NOP; mem_i = '0; imm_i = '0;
        @(negedge clk); @(negedge clk);
        check("R1 acc", acc_o, 0);
        check("R1 tmp", tmp_o, 0);
        check("R1 cy", cy_o, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_addc;
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 16; m++)
                for (int c = 0; c < 2; c++) begin
                    int s;
                    set_acc(4'(a));
                    set_cy(1'(c));
                    run_op(OP_ADDC, 4'(m), 4'hF);
                    s = a + m + c;
                    check("R2 acc", acc_o, s % 16);
                    check("R2 cy", cy_o, s / 16);
                end
    endtask

    task automatic t_add_nocarry;
        set_acc(4'd9); set_cy(1'b0);
        run_op(OP_ADDM, 4'd9, 4'd1);
        check("R3 addm acc", acc_o, 2);
        check("R3 addm cy", cy_o, 0);
        set_cy(1'b1);
        run_op(OP_ADDM, 4'd3, 4'd0);
        check("R3 addm acc cy-in ignored", acc_o, 5);
        check("R3 addm cy", cy_o, 1);
        run_op(OP_ADDI, 4'd7, 4'd12);
        check("R3 addi acc", acc_o, 1);
        check("R3 addi cy", cy_o, 1);
        set_cy(1'b0);
        run_op(OP_ADDI, 4'd0, 4'd15);
        check("R3 addi acc wrap", acc_o, 0);
        check("R3 addi cy", cy_o, 0);
    endtask

    task automatic t_logic;
        set_acc(4'b1100); set_cy(1'b1);
        run_op(OP_AND, 4'b1010, 4'hF);
        check("R4 and", acc_o, 4'b1000);
        check("R4 and cy", cy_o, 1);
        set_cy(1'b0);
        run_op(OP_OR, 4'b0011, 4'h0);
        check("R4 or", acc_o, 4'b1011);
        check("R4 or cy", cy_o, 0);
    endtask

    task automatic t_rar;
        set_acc(4'b0101); set_cy(1'b0);
        run_op(OP_RAR, '0, '0);
        check("R5 rar acc", acc_o, 4'b0010);
        check("R5 rar cy", cy_o, 1);
        run_op(OP_RAR, '0, '0);
        check("R5 rar acc cy-in", acc_o, 4'b1001);
        check("R5 rar cy", cy_o, 0);
    endtask

    task automatic t_carry;
        set_acc(4'd6);
        run_op(OP_SETC, 4'hF, 4'hF);
        check("R6 setc", cy_o, 1);
        check("R6 setc acc", acc_o, 6);
        run_op(OP_CLRC, 4'hF, 4'hF);
        check("R6 clrc", cy_o, 0);
        check("R6 clrc acc", acc_o, 6);
    endtask

    task automatic t_ext;
        set_acc(4'hA); run_op(OP_A2B, '0, '0);
        set_acc(4'h3);
        run_op(OP_LDE, '0, '0);
        check("R7 lde", ext_o, 8'hA3);
        set_acc(4'h5); run_op(OP_A2B, '0, '0);
        run_op(OP_ADDI, 4'h0, 4'h1);
        check("R7 ext unchanged by other ops", ext_o, 8'hA3);
        run_op(OP_SPLE, '0, '0);
        check("R8 sple tmp", tmp_o, 4'hA);
        check("R8 sple acc", acc_o, 4'h3);
    endtask

    task automatic t_xfer;
        set_acc(4'hC); run_op(OP_A2B, '0, '0);
        check("R9 a2b", tmp_o, 4'hC);
        set_acc(4'h2);
        run_op(OP_B2A, '0, '0);
        check("R9 b2a", acc_o, 4'hC);
        check("R9 b2a tmp kept", tmp_o, 4'hC);
    endtask

    task automatic t_idle;
        set_acc(4'h7); run_op(OP_A2B, '0, '0);
        set_acc(4'h4); set_cy(1'b1);
        run_op(OP_LDE, '0, '0);
        for (int c = 0; c < 4; c++) begin
            run_op((c == 0) ? 4'd0 : 4'(12 + c), 4'hF, 4'hF);
            check("R10 acc", acc_o, 4'h4);
            check("R10 tmp", tmp_o, 4'h7);
            check("R10 cy", cy_o, 1);
            check("R10 ext", ext_o, 8'h74);
        end
    endtask

    initial begin
        t_reset;
        t_addc;
        t_add_nocarry;
        t_logic;
        t_rar;
        t_carry;
        t_ext;
        t_xfer;
        t_idle;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule